// File: doc/BRIEF.md
# Idle-Gated Memory Port Selector

This block sits between a memory-mapped request stream and two downstream flash controller ports. One port is an octal-SPI controller. The other is a double-data-rate flash/RAM bus controller. Software chooses the target through a configuration register. Every request is sent to the applied port only, and responses are returned only from that same port.

A selection write does not change the routing at once. The new value is held as a pending request. It is applied only when the data path is idle, meaning no transaction is outstanding and no request is being presented. This way a transfer is never split across ports.

The selector never stalls traffic on its own. Quiescing the stream before a switch is left to software. A status register reports the applied port, the pending flag and the idle indication.

Top module: `mem_port_sel`

## Requirements
- R1: After reset the applied port is octal-SPI (selection value 0), no switch is pending and the path reports idle, so the status register reads 0x4.
- R2: Register at offset 0x0 holds the requested selection in bit 0 (0 = octal-SPI, 1 = DDR bus) and reads back the last written value. Register at offset 0x4 is read-only: bit 0 = applied port, bit 1 = pending, bit 2 = idle, other bits zero. Writes to offset 0x4 have no effect.
- R3: A presented request raises the request-valid of the applied port only; the other port's request-valid stays low. The upstream ready is the applied port's ready.
- R4: Upstream responses come only from the applied port; a response raised by the other port is ignored and does not change the outstanding count.
- R5: The outstanding count rises on each accepted request and falls on each response from the applied port. The path is idle only when this count is zero and no request is presented, including a request stalled by a not-ready port.
- R6: A write to offset 0x0 whose bit 0 differs from the applied port sets the pending flag. The applied port does not change while the path is not idle.
- R7: When pending is set and the path is idle in a cycle, the applied port takes the requested value at the next clock edge and pending clears at that edge.
- R8: While a switch is pending, new requests are still accepted and routed to the currently applied port without any stall added by the selector.
- R9: A write to offset 0x0 equal to the applied port clears the pending flag, which cancels a pending switch.
- R10: Address, write data and write-enable reach the applied port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Upstream request valid |
| req_ready_o | output | 1 | Upstream request ready (from applied port) |
| req_we_i | input | 1 | Request is a write |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Request write data |
| rsp_valid_o | output | 1 | Response valid from applied port |
| rsp_rdata_o | output | DATA_W | Response data |
| cfg_valid_i | input | 1 | Configuration access strobe |
| cfg_write_i | input | 1 | Configuration access is a write |
| cfg_addr_i | input | CFG_AW | Configuration byte offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for cfg_addr_i |
| sel_o | output | 1 | Applied port (0 octal-SPI, 1 DDR bus) |
| idle_o | output | 1 | Data path idle |
| oct_req_valid_o | output | 1 | Octal-SPI port request valid |
| oct_req_ready_i | input | 1 | Octal-SPI port request ready |
| oct_req_we_o | output | 1 | Octal-SPI port write enable |
| oct_req_addr_o | output | ADDR_W | Octal-SPI port address |
| oct_req_wdata_o | output | DATA_W | Octal-SPI port write data |
| oct_rsp_valid_i | input | 1 | Octal-SPI port response valid |
| oct_rsp_rdata_i | input | DATA_W | Octal-SPI port response data |
| ddr_req_valid_o | output | 1 | DDR bus port request valid |
| ddr_req_ready_i | input | 1 | DDR bus port request ready |
| ddr_req_we_o | output | 1 | DDR bus port write enable |
| ddr_req_addr_o | output | ADDR_W | DDR bus port address |
| ddr_req_wdata_o | output | DATA_W | DDR bus port write data |
| ddr_rsp_valid_i | input | 1 | DDR bus port response valid |
| ddr_rsp_rdata_i | input | DATA_W | DDR bus port response data |

## Verification
If the outstanding count is off by one, the fault shows up at the switch. With the count too high, idle never rises, the pending bit stays set in status and requests keep going to the old port, so responses carry the wrong port's signature. With the count too low, the route flips while a response is still owed. The lost response is then missing from the scoreboard.

A pending flag or applied register that is updated at the wrong time shows up on sel_o. It appears within one cycle of the first idle cycle, which the bench samples on exact cycles. If a stray response from the inactive port leaks through, it appears at once as an unexpected upstream response.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic {
    PORT_OCT = 1'b0,
    PORT_DDR = 1'b1
  } port_e;

  localparam int unsigned OFF_SEL  = 0;
  localparam int unsigned OFF_STAT = 4;

  localparam int unsigned ST_APPLIED = 0;
  localparam int unsigned ST_PEND    = 1;
  localparam int unsigned ST_IDLE    = 2;
endpackage

// File: rtl/mps_txn_tracker.sv
module mps_txn_tracker #(
  parameter int unsigned CNT_MAX = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic done_i,
  input  logic req_pres_i,
  output logic idle_o
);
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case ({acc_i, done_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign idle_o = (cnt_q == '0) && !req_pres_i;

  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !acc_i) |-> (cnt_q != '0));

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !done_i) |-> (cnt_q != CNT_W'(CNT_MAX)));
endmodule

// File: rtl/mps_cfg_regs.sv
module mps_cfg_regs
  import mps_pkg::*;
#(
  parameter int unsigned CFG_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic              cfg_write_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              idle_i,
  output port_e             applied_o,
  output logic              pend_o
);
  port_e req_q, applied_q;
  logic  pend_q;
  logic  wr_sel;
  logic  hit_sel, hit_stat;
  logic  unused_wdata;

  assign hit_sel      = (cfg_addr_i == CFG_AW'(OFF_SEL));
  assign hit_stat     = (cfg_addr_i == CFG_AW'(OFF_STAT));
  assign wr_sel       = cfg_valid_i && cfg_write_i && hit_sel;
  assign unused_wdata = ^cfg_wdata_i[31:1];

  // a write takes priority; apply happens no earlier than the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= PORT_OCT;
      applied_q <= PORT_OCT;
      pend_q    <= 1'b0;
    end else if (wr_sel) begin
      req_q  <= port_e'(cfg_wdata_i[0]);
      pend_q <= (port_e'(cfg_wdata_i[0]) != applied_q);
    end else if (pend_q && idle_i) begin
      applied_q <= req_q;
      pend_q    <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (hit_sel) begin
      cfg_rdata_o[0] = req_q;
    end else if (hit_stat) begin
      cfg_rdata_o[ST_APPLIED] = applied_q;
      cfg_rdata_o[ST_PEND]    = pend_q;
      cfg_rdata_o[ST_IDLE]    = idle_i;
    end
  end

  assign applied_o = applied_q;
  assign pend_o    = pend_q;

  // R6 R7
  switch_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(applied_q) |-> $past(idle_i));

  // R7
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(applied_q) |-> !pend_q);

  // R9
  no_pend_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel && (cfg_wdata_i[0] == applied_q)) |=> !pend_q);
endmodule

// File: rtl/mps_route.sv
module mps_route #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic [SEL_W-1:0]               sel_i,
  output logic [NPORTS-1:0]              port_valid_o,
  input  logic [NPORTS-1:0]              port_ready_i,
  input  logic [NPORTS-1:0]              port_rsp_valid_i,
  input  logic [NPORTS-1:0][DATA_W-1:0]  port_rsp_rdata_i,
  output logic                           rsp_valid_o,
  output logic [DATA_W-1:0]              rsp_rdata_o,
  output logic                           acc_o,
  output logic                           done_o
);
  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    assign port_valid_o[g] = req_valid_i && (sel_i == SEL_W'(g));
  end

  assign req_ready_o = port_ready_i[sel_i];
  assign rsp_valid_o = port_rsp_valid_i[sel_i];
  assign rsp_rdata_o = port_rsp_rdata_i[sel_i];
  assign acc_o       = req_valid_i && req_ready_o;
  assign done_o      = rsp_valid_o;
endmodule

// File: rtl/mem_port_sel.sv
module mem_port_sel
  import mps_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned CFG_AW    = 4,
  parameter int unsigned MAX_OUTST = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              cfg_valid_i,
  input  logic              cfg_write_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              sel_o,
  output logic              idle_o,
  output logic              oct_req_valid_o,
  input  logic              oct_req_ready_i,
  output logic              oct_req_we_o,
  output logic [ADDR_W-1:0] oct_req_addr_o,
  output logic [DATA_W-1:0] oct_req_wdata_o,
  input  logic              oct_rsp_valid_i,
  input  logic [DATA_W-1:0] oct_rsp_rdata_i,
  output logic              ddr_req_valid_o,
  input  logic              ddr_req_ready_i,
  output logic              ddr_req_we_o,
  output logic [ADDR_W-1:0] ddr_req_addr_o,
  output logic [DATA_W-1:0] ddr_req_wdata_o,
  input  logic              ddr_rsp_valid_i,
  input  logic [DATA_W-1:0] ddr_rsp_rdata_i
);
  localparam int unsigned NPORTS = 2;

  port_e                           applied;
  logic                            pend;
  logic                            idle;
  logic                            acc, done;
  logic [NPORTS-1:0]               port_valid;
  logic [NPORTS-1:0][DATA_W-1:0]   port_rdata;

  assign port_rdata = {ddr_rsp_rdata_i, oct_rsp_rdata_i};

  mps_cfg_regs #(
    .CFG_AW (CFG_AW)
  ) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_valid_i (cfg_valid_i),
    .cfg_write_i (cfg_write_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .idle_i      (idle),
    .applied_o   (applied),
    .pend_o      (pend)
  );

  mps_txn_tracker #(
    .CNT_MAX (MAX_OUTST)
  ) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .done_i     (done),
    .req_pres_i (req_valid_i),
    .idle_o     (idle)
  );

  mps_route #(
    .NPORTS (NPORTS),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_route (
    .req_valid_i      (req_valid_i),
    .req_ready_o      (req_ready_o),
    .sel_i            (applied),
    .port_valid_o     (port_valid),
    .port_ready_i     ({ddr_req_ready_i, oct_req_ready_i}),
    .port_rsp_valid_i ({ddr_rsp_valid_i, oct_rsp_valid_i}),
    .port_rsp_rdata_i (port_rdata),
    .rsp_valid_o      (rsp_valid_o),
    .rsp_rdata_o      (rsp_rdata_o),
    .acc_o            (acc),
    .done_o           (done)
  );

  assign oct_req_valid_o = port_valid[0];
  assign ddr_req_valid_o = port_valid[1];
  assign oct_req_we_o    = req_we_i;
  assign oct_req_addr_o  = req_addr_i;
  assign oct_req_wdata_o = req_wdata_i;
  assign ddr_req_we_o    = req_we_i;
  assign ddr_req_addr_o  = req_addr_i;
  assign ddr_req_wdata_o = req_wdata_i;

  assign sel_o  = applied;
  assign idle_o = idle;

  // R3
  one_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({oct_req_valid_o, ddr_req_valid_o}));

  // R3 R6
  valid_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oct_req_valid_o || ddr_req_valid_o) |-> (req_valid_i && !idle_o));

  // R8
  pend_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && req_valid_i) |-> (oct_req_valid_o || ddr_req_valid_o));
endmodule

// File: tb/mem_port_sel_bench.sv
module mem_port_sel_bench;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 64;
  localparam logic [31:0] TAG_OCT = 32'h0C7A_0000;
  localparam logic [31:0] TAG_DDR = 32'hD0D0_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          cfg_valid = 1'b0, cfg_write = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0, cfg_rdata;
  logic          sel, idle;
  logic          oct_v, oct_we, ddr_v, ddr_we;
  logic [AW-1:0] oct_a, ddr_a;
  logic [DW-1:0] oct_wd, ddr_wd;
  logic [1:0]    p_ready = 2'b11, p_hold = 2'b00, p_stray = 2'b00;
  logic [1:0]    p_rv = 2'b00;
  logic [DW-1:0] p_rd [2];

  mem_port_sel u_mem_port_sel (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .cfg_valid_i(cfg_valid), .cfg_write_i(cfg_write), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .sel_o(sel), .idle_o(idle),
    .oct_req_valid_o(oct_v), .oct_req_ready_i(p_ready[0]), .oct_req_we_o(oct_we),
    .oct_req_addr_o(oct_a), .oct_req_wdata_o(oct_wd),
    .oct_rsp_valid_i(p_rv[0]), .oct_rsp_rdata_i(p_rd[0]),
    .ddr_req_valid_o(ddr_v), .ddr_req_ready_i(p_ready[1]), .ddr_req_we_o(ddr_we),
    .ddr_req_addr_o(ddr_a), .ddr_req_wdata_o(ddr_wd),
    .ddr_rsp_valid_i(p_rv[1]), .ddr_rsp_rdata_i(p_rd[1])
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] pq0[$], pq1[$];
  logic          exp_sel = 1'b0;

  function automatic logic [DW-1:0] sig(logic p, logic [AW-1:0] a, logic [DW-1:0] d, logic we);
    return {(p ? TAG_DDR : TAG_OCT), a} ^ d ^ {{(DW-1){1'b0}}, we};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // port models: capture accepted requests, answer in order
  always @(posedge clk) begin
    if (oct_v && p_ready[0]) pq0.push_back(sig(1'b0, oct_a, oct_wd, oct_we));
    if (ddr_v && p_ready[1]) pq1.push_back(sig(1'b1, ddr_a, ddr_wd, ddr_we));
    if (p_rv[0] && pq0.size() > 0 && !p_stray[0]) void'(pq0.pop_front());
    if (p_rv[1] && pq1.size() > 0 && !p_stray[1]) void'(pq1.pop_front());
  end

  always @(negedge clk) begin
    #1;
    p_rv[0] = p_stray[0] || (pq0.size() > 0 && !p_hold[0]);
    p_rd[0] = p_stray[0] ? 64'hBAD0_BAD0_BAD0_BAD0 : (pq0.size() > 0 ? pq0[0] : '0);
    p_rv[1] = p_stray[1] || (pq1.size() > 0 && !p_hold[1]);
    p_rd[1] = p_stray[1] ? 64'hBAD1_BAD1_BAD1_BAD1 : (pq1.size() > 0 ? pq1[0] : '0);
  end

  // monitor / scoreboard (R3 R4 R10)
  always @(posedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4: unexpected response actual %h expected none", rsp_rdata);
      end else begin
        check("R3/R4/R10 response", rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic send(logic [AW-1:0] a, logic [DW-1:0] d, logic we);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wdata = d; req_we = we;
    do @(posedge clk); while (!req_ready);
    exp_q.push_back(sig(exp_sel, a, d, we));
  endtask

  task automatic req_off();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_write = 1'b0;
  endtask

  task automatic cfg_rd(logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(idle && exp_q.size() == 0));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_rd(4'h4, rd); check("R1 status", rd, 32'h4);
    check("R1 sel", sel, 0);

    // traffic on octal port
    for (int i = 0; i < 4; i++) send(32'h100 + i * 8, 64'h1111_0000_0000_0000 * i, i[0]);
    req_off();
    wait_idle();

    // stalled request keeps the path busy with zero outstanding
    @(negedge clk);
    p_ready[0] = 1'b0; req_valid = 1'b1; req_addr = 32'h200; req_wdata = 64'h5; req_we = 1'b0;
    @(negedge clk);
    check("R5 idle while stalled", idle, 0);
    cfg_rd(4'h4, rd); check("R5 status while stalled", rd, 32'h0);
    p_ready[0] = 1'b1;
    @(posedge clk);
    exp_q.push_back(sig(1'b0, 32'h200, 64'h5, 1'b0));
    req_off();
    wait_idle();

    // deferred switch to DDR bus
    p_hold[0] = 1'b1;
    send(32'h300, 64'hAAAA, 1'b1);
    req_off();
    cfg_wr(4'h0, 32'h1);
    cfg_rd(4'h4, rd); check("R6 pending status", rd, 32'h2);
    cfg_rd(4'h0, rd); check("R2 sel readback", rd, 32'h1);
    send(32'h308, 64'hBBBB, 1'b0);
    check("R8 routed to old port", {oct_v, ddr_v}, 2'b10);
    req_off();
    repeat (3) @(negedge clk);
    check("R6 held while busy", sel, 0);
    p_hold[0] = 1'b0;
    do @(negedge clk); while (!idle);
    check("R6 first idle cycle", sel, 0);
    @(negedge clk);
    check("R7 applied next edge", sel, 1);
    cfg_rd(4'h4, rd); check("R7 status after switch", rd, 32'h5);
    exp_sel = 1'b1;

    // traffic on DDR port
    for (int i = 0; i < 3; i++) send(32'h4000 + i * 16, 64'hFEED_0000 + i, ~i[0]);
    req_off();
    wait_idle();

    // stray response from inactive port
    @(negedge clk); p_stray[0] = 1'b1;
    @(negedge clk); p_stray[0] = 1'b0;
    @(negedge clk);
    cfg_rd(4'h4, rd); check("R4 stray ignored", rd, 32'h5);

    // cancel a pending switch
    p_hold[1] = 1'b1;
    send(32'h5000, 64'h77, 1'b0);
    req_off();
    cfg_wr(4'h0, 32'h0);
    cfg_rd(4'h4, rd); check("R6 pending set", rd, 32'h3);
    cfg_wr(4'h0, 32'h1);
    cfg_rd(4'h4, rd); check("R9 pending cleared", rd, 32'h1);
    p_hold[1] = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    check("R9 stays on DDR", sel, 1);

    // status register is read-only
    cfg_wr(4'h4, 32'hFFFF_FFFF);
    @(negedge clk);
    cfg_rd(4'h4, rd); check("R2 status write ignored", rd, 32'h5);
    cfg_rd(4'h0, rd); check("R2 sel unchanged", rd, 32'h1);

    // switch back while idle
    cfg_wr(4'h0, 32'h0);
    @(negedge clk);
    check("R7 switch when idle", sel, 0);
    exp_sel = 1'b0;
    send(32'h6000, 64'h1234_5678_9ABC_DEF0, 1'b1);
    req_off();
    wait_idle();
    repeat (2) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule